// File: doc/BRIEF.md
# Multi-Bank Chip-Select and Wait-State Controller

This block sits between a bus master and up to eight external memory devices. Each bank has its own configuration: a base address, a power-of-two block size from 32 KB to 256 MB, a wait-state count from 0 to 15, a data port width and a write-protect flag. When the master issues a request, the block compares the 32-bit address against every valid bank. It asserts the chip select of the matching bank and holds it for the programmed number of wait states. It then returns a one-cycle transfer acknowledge. It also reports the port width of the selected bank, so the bus can size the data transfer.

Bank 0 is usable as soon as reset ends. It covers the bottom 256 MB with the slowest timing, and its port width comes from a strap input that is sampled during reset. This lets the processor fetch boot code before software has programmed any bank. A write that hits a protected bank never reaches the device. The block drops the write and raises an error pulse instead. A single configuration port writes all fields of one bank at once.

Top module: `csel_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `cs`, `ta` and `err` are all low. After reset, bank 0 is valid with base 0, size code 13, 15 wait states, no write protection, and the port width taken from `boot_width`. Every other bank is invalid.
- R2: A valid bank with size code c (0..13) covers 2^(15+c) bytes. An address matches the bank when the address bits at position 15+c and above equal the same bits of the bank's base. Size codes above 13 act as 13.
- R3: An address that matches no valid bank produces no chip select, no acknowledge and no error. A bank whose valid bit is clear never matches.
- R4: When several valid banks match, only the chip select of the lowest-numbered bank is asserted.
- R5: An access starts at the clock edge that samples `req` high while the block is idle and a bank matches. From that edge until the acknowledge cycle, exactly one chip-select bit is high and it does not change. `ta` is high for exactly one cycle, N+1 cycles after the start edge, where N is the bank's wait-state count. All chip selects are low in the cycle after `ta`.
- R6: A write (`req_wr`=1) that matches a bank with write protection set asserts no chip select and no `ta`. Instead, `err` is high for the one cycle that follows the request edge. Reads of that bank, and writes to unprotected banks, proceed normally.
- R7: While a chip select is high, `acc_width` shows the selected bank's port width: 0 means 8-bit, 1 means 16-bit and 2 means 32-bit.
- R8: A `req` that arrives while an access is in progress is ignored. It starts no second access and causes no error.
- R9: When `cfg_we` is high at a clock edge, it writes all fields of bank `cfg_bank` in one step. The new values govern every access that starts after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_width | input | 2 | Boot bank port width strap, sampled during reset |
| cfg_we | input | 1 | Write one bank's configuration |
| cfg_bank | input | 3 | Bank index to write |
| cfg_valid | input | 1 | Bank enable |
| cfg_base | input | 32 | Bank base address |
| cfg_size | input | 4 | Block size code (2^(15+code) bytes) |
| cfg_wait | input | 4 | Wait-state count |
| cfg_width | input | 2 | Port width code |
| cfg_wp | input | 1 | Write-protect flag |
| req | input | 1 | Access request |
| req_addr | input | 32 | Access address |
| req_wr | input | 1 | Access is a write |
| cs | output | 8 | Per-bank chip selects, active high |
| ta | output | 1 | Transfer acknowledge pulse |
| err | output | 1 | Protected-write error pulse |
| acc_width | output | 2 | Port width of the current access |

## Verification
The bench uses the default build: eight banks, a 32-bit address, 4-bit wait and size fields, and a minimum block of 32 KB. With these values it can sweep every wait count from 0 to 15 and every size code from 0 to 13 on real banks. For each size code it tests the last address inside the block and the first address past it. Eight banks allow overlap tests on both sides of the boot bank, including a later bank that overlaps bank 0. They also leave a dedicated bank free for the protected-write cases.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int CS_AW     = 32;
    localparam int CS_WAIT_W = 4;
    localparam int CS_SIZE_W = 4;

    typedef enum logic [1:0] {
        PW_8   = 2'd0,
        PW_16  = 2'd1,
        PW_32  = 2'd2,
        PW_RSV = 2'd3
    } port_w_e;

    typedef struct packed {
        logic                 valid;
        logic                 wp;
        port_w_e              width;
        logic [CS_SIZE_W-1:0] size;
        logic [CS_WAIT_W-1:0] waits;
        logic [CS_AW-1:0]     base;
    } bank_cfg_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_ACK  = 2'd2
    } seq_st_e;

    // Mask keeping the address bits above the bank's block size.
    function automatic logic [CS_AW-1:0] size_mask(input logic [CS_SIZE_W-1:0] code,
                                                   input int min_shift,
                                                   input int max_code);
        int c;
        c = (int'(code) > max_code) ? max_code : int'(code);
        return {CS_AW{1'b1}} << (min_shift + c);
    endfunction

endpackage

// File: rtl/csel_bankregs.sv
module csel_bankregs
    import csel_pkg::*;
#(
    parameter int NBANK    = 8,
    parameter int MAX_CODE = 13,
    localparam int IDX_W   = $clog2(NBANK)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            boot_width,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  bank_cfg_t             wr_cfg,
    output bank_cfg_t [NBANK-1:0] cfg
);

    localparam logic [CS_SIZE_W-1:0] BOOT_SIZE = CS_SIZE_W'(MAX_CODE);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                if (b == 0) begin
                    cfg[b].valid <= 1'b1;
                    cfg[b].wp    <= 1'b0;
                    cfg[b].width <= port_w_e'(boot_width);
                    cfg[b].size  <= BOOT_SIZE;
                    cfg[b].waits <= '1;
                    cfg[b].base  <= '0;
                end else begin
                    cfg[b] <= '0;
                end
            end else if (wr_en && (wr_idx == IDX_W'(b))) begin
                cfg[b] <= wr_cfg;
            end
        end
    end

    AST_BOOT_VALID: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg[0].valid && cfg[0].base == '0 && cfg[0].waits == '1)); // R1

endmodule

// File: rtl/csel_decode.sv
module csel_decode
    import csel_pkg::*;
#(
    parameter int NBANK     = 8,
    parameter int MIN_SHIFT = 15,
    parameter int MAX_CODE  = 13,
    localparam int IDX_W    = $clog2(NBANK)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  bank_cfg_t [NBANK-1:0] cfg,
    input  logic [CS_AW-1:0]      addr,
    output logic                  hit_any,
    output logic [IDX_W-1:0]      hit_idx,
    output bank_cfg_t             hit_cfg
);

    logic [NBANK-1:0] hit_vec;

    for (genvar b = 0; b < NBANK; b++) begin : g_cmp
        logic [CS_AW-1:0] msk;
        assign msk        = size_mask(cfg[b].size, MIN_SHIFT, MAX_CODE);
        assign hit_vec[b] = cfg[b].valid && ((addr & msk) == (cfg[b].base & msk));
    end

    // Lowest index wins: scan downward so the last assignment is the lowest hit.
    always_comb begin
        hit_idx = '0;
        for (int b = NBANK - 1; b >= 0; b--) begin
            if (hit_vec[b]) hit_idx = IDX_W'(b);
        end
    end

    assign hit_any = |hit_vec;
    assign hit_cfg = cfg[hit_idx];

    AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (rst)
        hit_any |-> (hit_vec[hit_idx] &&
                     ((hit_vec & ((NBANK'(1) << hit_idx) - NBANK'(1))) == '0))); // R4

    AST_INVALID_NOHIT: assert property (@(posedge clk) disable iff (rst)
        hit_any |-> cfg[hit_idx].valid); // R3

endmodule

// File: rtl/csel_seq.sv
module csel_seq
    import csel_pkg::*;
#(
    parameter int NBANK  = 8,
    localparam int IDX_W = $clog2(NBANK)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             req_wr,
    input  logic             hit_any,
    input  logic [IDX_W-1:0] hit_idx,
    input  bank_cfg_t        hit_cfg,
    output logic [NBANK-1:0] cs,
    output logic             ta,
    output logic             err,
    output logic [1:0]       acc_width
);

    seq_st_e              st;
    logic [CS_WAIT_W-1:0] cnt;
    logic [IDX_W-1:0]     cur_idx;
    port_w_e              cur_w;
    logic                 err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            cnt     <= '0;
            cur_idx <= '0;
            cur_w   <= PW_8;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (st)
                SQ_IDLE: begin
                    if (req && hit_any) begin
                        if (req_wr && hit_cfg.wp) begin
                            err_q <= 1'b1;
                        end else begin
                            st      <= SQ_WAIT;
                            cnt     <= hit_cfg.waits;
                            cur_idx <= hit_idx;
                            cur_w   <= hit_cfg.width;
                        end
                    end
                end
                SQ_WAIT: begin
                    if (cnt == '0) st  <= SQ_ACK;
                    else           cnt <= cnt - 1'b1;
                end
                SQ_ACK:  st <= SQ_IDLE;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign cs        = (st != SQ_IDLE) ? (NBANK'(1) << cur_idx) : '0;
    assign ta        = (st == SQ_ACK);
    assign err       = err_q;
    assign acc_width = (st != SQ_IDLE) ? cur_w : PW_8;

    // Independent latency tracker for the acknowledge check.
    logic [CS_WAIT_W:0]   chk_cyc;
    logic [CS_WAIT_W-1:0] chk_n;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_cyc <= '0;
            chk_n   <= '0;
        end else if (st == SQ_IDLE && req && hit_any && !(req_wr && hit_cfg.wp)) begin
            chk_cyc <= '0;
            chk_n   <= hit_cfg.waits;
        end else if (chk_cyc != '1) begin
            chk_cyc <= chk_cyc + 1'b1;
        end
    end

    AST_TA_LATENCY: assert property (@(posedge clk) disable iff (rst)
        ta |-> (chk_cyc == ({1'b0, chk_n} + 1'b1))); // R5
    AST_TA_PULSE: assert property (@(posedge clk) disable iff (rst)
        ta |=> (!ta && cs == '0)); // R5
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs)); // R5
    AST_CS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (|cs && !ta) |=> $stable(cs)); // R5
    AST_TA_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        ta |-> (|cs)); // R5
    AST_ERR_NO_CS: assert property (@(posedge clk) disable iff (rst)
        err |-> (cs == '0 && !ta)); // R6
    AST_BUSY_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (|cs) |=> !err); // R8

endmodule

// File: rtl/csel_ctrl.sv
module csel_ctrl
    import csel_pkg::*;
#(
    parameter int NBANK     = 8,
    parameter int MIN_SHIFT = 15,
    parameter int MAX_CODE  = 13,
    localparam int IDX_W    = $clog2(NBANK)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           boot_width,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_bank,
    input  logic                 cfg_valid,
    input  logic [CS_AW-1:0]     cfg_base,
    input  logic [CS_SIZE_W-1:0] cfg_size,
    input  logic [CS_WAIT_W-1:0] cfg_wait,
    input  logic [1:0]           cfg_width,
    input  logic                 cfg_wp,
    input  logic                 req,
    input  logic [CS_AW-1:0]     req_addr,
    input  logic                 req_wr,
    output logic [NBANK-1:0]     cs,
    output logic                 ta,
    output logic                 err,
    output logic [1:0]           acc_width
);

    bank_cfg_t [NBANK-1:0] cfg;
    bank_cfg_t             wr_cfg;
    bank_cfg_t             hit_cfg;
    logic                  hit_any;
    logic [IDX_W-1:0]      hit_idx;

    always_comb begin
        wr_cfg.valid = cfg_valid;
        wr_cfg.wp    = cfg_wp;
        wr_cfg.width = port_w_e'(cfg_width);
        wr_cfg.size  = cfg_size;
        wr_cfg.waits = cfg_wait;
        wr_cfg.base  = cfg_base;
    end

    csel_bankregs #(.NBANK(NBANK), .MAX_CODE(MAX_CODE)) u_regs (
        .clk(clk), .rst(rst), .boot_width(boot_width),
        .wr_en(cfg_we), .wr_idx(cfg_bank), .wr_cfg(wr_cfg), .cfg(cfg)
    );

    csel_decode #(.NBANK(NBANK), .MIN_SHIFT(MIN_SHIFT), .MAX_CODE(MAX_CODE)) u_dec (
        .clk(clk), .rst(rst), .cfg(cfg), .addr(req_addr),
        .hit_any(hit_any), .hit_idx(hit_idx), .hit_cfg(hit_cfg)
    );

    csel_seq #(.NBANK(NBANK)) u_seq (
        .clk(clk), .rst(rst), .req(req), .req_wr(req_wr),
        .hit_any(hit_any), .hit_idx(hit_idx), .hit_cfg(hit_cfg),
        .cs(cs), .ta(ta), .err(err), .acc_width(acc_width)
    );

endmodule

// File: tb/sim_csel_ctrl.sv
module sim_csel_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  boot_width = 2'd1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_bank = '0;
    logic        cfg_valid = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [3:0]  cfg_size = '0;
    logic [3:0]  cfg_wait = '0;
    logic [1:0]  cfg_width = '0;
    logic        cfg_wp = 1'b0;
    logic        req = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_wr = 1'b0;
    logic [7:0]  cs;
    logic        ta;
    logic        err;
    logic [1:0]  acc_width;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    csel_ctrl u0 (
        .clk(clk), .rst(rst), .boot_width(boot_width),
        .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_valid(cfg_valid),
        .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_wait(cfg_wait),
        .cfg_width(cfg_width), .cfg_wp(cfg_wp),
        .req(req), .req_addr(req_addr), .req_wr(req_wr),
        .cs(cs), .ta(ta), .err(err), .acc_width(acc_width)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic set_bank(input int b, input bit v, input logic [31:0] base,
                            input int sz, input int w, input int pw, input bit wp);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = 3'(b); cfg_valid = v; cfg_base = base;
        cfg_size = 4'(sz); cfg_wait = 4'(w); cfg_width = 2'(pw); cfg_wp = wp;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one request; lat = cycles from start edge to ta, -1 if none.
    task automatic do_acc(input logic [31:0] a, input bit w,
                          output int lat, output logic [7:0] csv, output bit errv,
                          output logic [1:0] wid, output bit err_long, output logic [7:0] cs_after);
        @(negedge clk);
        req = 1'b1; req_addr = a; req_wr = w;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        lat = -1; csv = '0; errv = err; wid = '0; err_long = 1'b0; cs_after = '0;
        for (int i = 0; i < 40; i++) begin
            if (i > 0) @(negedge clk);
            if (i == 1 && err) err_long = 1'b1;
            if (cs != '0 && csv == '0) begin
                csv = cs;
                wid = acc_width;
            end
            if (ta) begin
                lat = i;
                break;
            end
        end
        @(negedge clk);
        cs_after = cs;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual=%0d expected<100000", cycles);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        int lat;
        logic [7:0] csv, csa;
        bit ev, el;
        logic [1:0] wid;
        logic [31:0] blk;

        repeat (3) @(negedge clk);
        chk(cs == '0 && !ta && !err, "R1", "outputs in reset", {cs, ta, err}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cs == '0 && !ta && !err, "R1", "outputs after reset", {cs, ta, err}, 0);

        // Boot bank
        do_acc(32'h0000_1234, 1'b0, lat, csv, ev, wid, el, csa);
        chk(csv == 8'h01, "R1", "boot cs", csv, 8'h01);
        chk(lat == 16, "R1", "boot latency", lat, 16);
        chk(wid == 2'd1, "R7", "boot width", wid, 1);
        chk(csa == '0, "R5", "cs drops after ta", csa, 0);
        do_acc(32'h0FFF_FFFF, 1'b1, lat, csv, ev, wid, el, csa);
        chk(csv == 8'h01 && lat == 16 && !ev, "R2", "boot top address", csv, 8'h01);
        do_acc(32'h1000_0000, 1'b0, lat, csv, ev, wid, el, csa);
        chk(csv == '0 && lat == -1 && !ev, "R3", "unmapped address", csv, 0);

        // Wait-state sweep on bank 1
        for (int w = 0; w < 16; w++) begin
            set_bank(1, 1'b1, 32'h2000_0000, 0, w, 2, 1'b0);
            do_acc(32'h2000_0010, 1'b0, lat, csv, ev, wid, el, csa);
            chk(lat == w + 1, "R5", $sformatf("latency waits=%0d", w), lat, w + 1);
            chk(csv == 8'h02 && csa == '0, "R9", "bank1 cs after config", csv, 8'h02);
        end
        chk(wid == 2'd2, "R7", "32-bit width", wid, 2);

        // Size sweep on bank 2
        for (int c = 0; c < 14; c++) begin
            set_bank(2, 1'b1, 32'h4000_0000, c, 0, 0, 1'b0);
            blk = 32'h1 << (15 + c);
            do_acc(32'h4000_0000 + blk - 1, 1'b0, lat, csv, ev, wid, el, csa);
            chk(csv == 8'h04 && lat == 1, "R2", $sformatf("last in block code=%0d", c), csv, 8'h04);
            chk(wid == 2'd0, "R7", "8-bit width", wid, 0);
            do_acc(32'h4000_0000 + blk, 1'b0, lat, csv, ev, wid, el, csa);
            chk(csv == '0 && lat == -1, "R2", $sformatf("first past block code=%0d", c), csv, 0);
        end
        do_acc(32'h3FFF_FFFF, 1'b0, lat, csv, ev, wid, el, csa);
        chk(csv == '0 && lat == -1, "R2", "below base", csv, 0);

        // Invalid bank
        set_bank(2, 1'b0, 32'h4000_0000, 13, 0, 0, 1'b0);
        do_acc(32'h4000_0000, 1'b0, lat, csv, ev, wid, el, csa);
        chk(csv == '0 && lat == -1 && !ev, "R3", "invalid bank", csv, 0);

        // Priority
        set_bank(3, 1'b1, 32'h6000_0000, 2, 2, 1, 1'b0);
        set_bank(5, 1'b1, 32'h6000_0000, 2, 5, 2, 1'b0);
        do_acc(32'h6000_0100, 1'b0, lat, csv, ev, wid, el, csa);
        chk(csv == 8'h08 && lat == 3, "R4", "bank3 over bank5", csv, 8'h08);
        set_bank(3, 1'b0, 32'h6000_0000, 2, 2, 1, 1'b0);
        do_acc(32'h6000_0100, 1'b0, lat, csv, ev, wid, el, csa);
        chk(csv == 8'h20 && lat == 6, "R4", "bank5 alone", csv, 8'h20);
        set_bank(4, 1'b1, 32'h0000_0000, 0, 0, 2, 1'b0);
        do_acc(32'h0000_0100, 1'b0, lat, csv, ev, wid, el, csa);
        chk(csv == 8'h01 && lat == 16, "R4", "bank0 over bank4", csv, 8'h01);

        // Write protection
        set_bank(6, 1'b1, 32'h7000_0000, 0, 1, 2, 1'b1);
        do_acc(32'h7000_0040, 1'b1, lat, csv, ev, wid, el, csa);
        chk(ev, "R6", "err after protected write", ev, 1);
        chk(!el, "R6", "err lasts one cycle", el, 0);
        chk(csv == '0 && lat == -1, "R6", "no cs on protected write", csv, 0);
        do_acc(32'h7000_0040, 1'b0, lat, csv, ev, wid, el, csa);
        chk(csv == 8'h40 && lat == 2 && !ev, "R6", "read of protected bank", csv, 8'h40);
        do_acc(32'h2000_0000, 1'b1, lat, csv, ev, wid, el, csa);
        chk(csv == 8'h02 && !ev, "R6", "write to unprotected bank", csv, 8'h02);

        // Request during an access
        set_bank(1, 1'b1, 32'h2000_0000, 0, 3, 2, 1'b0);
        @(negedge clk);
        req = 1'b1; req_addr = 32'h2000_0000; req_wr = 1'b0;
        @(negedge clk);
        req_addr = 32'h6000_0000;
        @(negedge clk);
        req = 1'b0;
        chk(cs == 8'h02, "R8", "cs held despite new req", cs, 8'h02);
        begin
            bit bad = 1'b0;
            repeat (8) begin
                @(negedge clk);
                if (cs != '0 && cs != 8'h02) bad = 1'b1;
                if (err) bad = 1'b1;
            end
            chk(!bad && cs == '0, "R8", "no second access", cs, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule